// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Bank

The block holds a set of independent down-counting channels behind a small register window, reached through a single-cycle synchronous register bus. Each channel has a control word, an interval value and a count that can be read back. A channel counts on pulses from one of several tick-enable inputs, picked per channel. A power-of-two prescaler can slow those pulses down. In periodic mode the channel restarts from its interval each time it runs out. In one-shot mode it halts at zero.

Every time a channel expires it latches a pending flag. Software clears that flag by writing a one to it. One interrupt line goes high while any pending flag is set whose enable bit is also set. Stopping a channel does not take effect at once: the channel keeps counting for a fixed number of its selected source ticks after software clears its enable. A counter that increments can be built by setting the interval to all ones and reading the inverse of the count.

Top module: `countdown_timer_bank`

## Requirements
- R1: Address map (byte offsets, word aligned):
  - 0x00 is the interrupt-enable word. Bit n belongs to channel n.
  - 0x04 is the pending-status word. Bit n belongs to channel n.
  - Channel n has its control word at 0x10*n+0x10, its interval at 0x10*n+0x14 and its count at 0x10*n+0x18.
  - Any other offset, including one that is not word aligned or that names a channel beyond the last, reads as 0.
- R2: Control word fields:
  - Bit 0 is run.
  - Bit 1 is reload.
  - Bits 3:2 select the tick input.
  - Bits 6:4 are the prescale exponent.
  - Bit 7 is one-shot.
  - Writing 1 to bit 1 makes the channel copy its interval into the count on its next counting tick. Bit 1 always reads back 0; the other fields read back as written.
- R3: In periodic mode, each counting tick lowers the count by one. A tick that finds the count at 1 is an expiry: it reloads the interval and sets the channel's pending bit, and the channel keeps running.
- R4: In one-shot mode, an expiry sets the count to 0, clears the run bit in the control word and halts the channel. Later ticks leave the count unchanged.
- R5: With prescale exponent p, only every 2^p-th selected source tick after the channel starts is a counting tick. With p = 0, every selected tick counts.
- R6: Only the tick input named by bits 3:2 advances a channel. Pulses on the other tick inputs have no effect on its count.
- R7: After software clears the run bit of a running channel, the channel goes on counting for exactly 2 more selected source ticks, then stops. Later ticks leave the count unchanged.
- R8: An expiry sets the pending bit whether or not its interrupt is enabled. Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. An expiry in the same cycle as a clear wins.
- R9: The interrupt output is high exactly when some channel has both its pending bit and its enable bit set.
- R10: The count register ignores writes. With an interval of 0xFFFFFFFF, the count runs down through the full 32-bit range, so its bitwise inverse increases by one per counting tick.
- R11: After reset, every register reads 0 and the interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | AW (8) | Byte address of the register access |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | CW (32) | Write data |
| reg_rdata | output | CW (32) | Read data for reg_addr, same cycle |
| tick_src | input | NSRC (4) | Tick-enable pulses, one per source |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume that tick inputs are single-cycle enables sampled on the clock, and that a control write to a channel may land in the same cycle as that channel's expiry. Both the one-shot property and the pending-bit properties therefore exclude cycles that carry a conflicting write. The stimulus issues each register access alone, with no tick pulse in that cycle, and raises each tick for one clock with a gap after it. This makes every count value fall on a known cycle. Same-cycle write and expiry collisions are left to the assertions' exclusions and are not driven on purpose.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  // Control word; bit order is software-visible.
  typedef struct packed {
    logic       oneshot;  // bit 7
    logic [2:0] presc;    // bits 6:4
    logic [1:0] src;      // bits 3:2
    logic       reload;   // bit 1
    logic       run;      // bit 0
  } ctrl_t;

  localparam int CTRL_W = 8;
  localparam int DIV_W  = 7;

  // Low-bit mask for a 2^p divider.
  function automatic logic [DIV_W-1:0] presc_mask(input logic [2:0] p);
    logic [DIV_W:0] one_hot;
    one_hot = (DIV_W+1)'(1) << p;
    return DIV_W'(one_hot - (DIV_W+1)'(1));
  endfunction

endpackage

// File: rtl/tmr_tick_select.sv
module tmr_tick_select #(
  parameter int NSRC = 4,
  parameter int SRCW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] tick_src,
  input  logic [SRCW-1:0] sel,
  input  logic [2:0]      presc,
  input  logic            run,
  output logic            src_tick,
  output logic            cnt_tick
);
  import tmr_pkg::*;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    src_tick = 1'b0;
    for (int s = 0; s < NSRC; s++)
      if (sel == SRCW'(s)) src_tick = tick_src[s];
  end

  assign mask     = presc_mask(presc);
  assign cnt_tick = run && src_tick && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (!run)     div_q <= '0;
    else if (src_tick) div_q <= div_q + DIV_W'(1);
  end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW         = 32,
  parameter int NSRC       = 4,
  parameter int STOP_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              ival_we,
  input  logic [CW-1:0]     wdata,
  input  logic [NSRC-1:0]   tick_src,
  output tmr_pkg::ctrl_t    ctrl_rd,
  output logic [CW-1:0]     ival,
  output logic [CW-1:0]     count,
  output logic              expire,
  output logic              active,
  output logic              oneshot
);
  import tmr_pkg::*;

  localparam int STW = $clog2(STOP_TICKS + 1);

  ctrl_t          ctrl_q;
  ctrl_t          wr_ctrl;
  logic           pend_q;
  logic [CW-1:0]  ival_q;
  logic [CW-1:0]  cnt_q;
  logic           active_q;
  logic [STW-1:0] stop_q;
  logic           src_tick;
  logic           cnt_tick;
  logic           stop_done;

  // Next count on a counting tick.
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] cur,
                                               input logic [CW-1:0] iv,
                                               input logic          pend,
                                               input logic          one);
    if (pend)                  return iv;
    else if (cur == CW'(1))    return one ? '0 : iv;
    else                       return cur - CW'(1);
  endfunction

  assign wr_ctrl = ctrl_t'(wdata[CTRL_W-1:0]);

  tmr_tick_select #(.NSRC(NSRC), .SRCW(2)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_src (tick_src),
    .sel      (ctrl_q.src),
    .presc    (ctrl_q.presc),
    .run      (active_q),
    .src_tick (src_tick),
    .cnt_tick (cnt_tick)
  );

  assign expire    = cnt_tick && !pend_q && (cnt_q == CW'(1));
  assign stop_done = active_q && !ctrl_q.run && src_tick &&
                     (stop_q == STW'(STOP_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pend_q   <= 1'b0;
      ival_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      stop_q   <= '0;
    end else begin
      if (ival_we) ival_q <= wdata;

      if (cnt_tick) begin
        cnt_q  <= step_count(cnt_q, ival_q, pend_q, ctrl_q.oneshot);
        pend_q <= 1'b0;
        if (expire && ctrl_q.oneshot) begin
          active_q   <= 1'b0;
          ctrl_q.run <= 1'b0;
        end
      end

      if (active_q && !ctrl_q.run && src_tick) begin
        if (stop_done) begin
          active_q <= 1'b0;
          stop_q   <= '0;
        end else begin
          stop_q <= stop_q + STW'(1);
        end
      end

      if (ctrl_we) begin
        ctrl_q        <= wr_ctrl;
        ctrl_q.reload <= 1'b0;
        if (wr_ctrl.reload) pend_q <= 1'b1;
        if (wr_ctrl.run) begin
          active_q <= 1'b1;
          stop_q   <= '0;
        end
      end
    end
  end

  assign ctrl_rd = ctrl_q;
  assign ival    = ival_q;
  assign count   = cnt_q;
  assign active  = active_q;
  assign oneshot = ctrl_q.oneshot;

endmodule

// File: rtl/countdown_timer_bank.sv
module countdown_timer_bank #(
  parameter int NCH        = 2,
  parameter int CW         = 32,
  parameter int AW         = 8,
  parameter int NSRC       = 4,
  parameter int STOP_TICKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   reg_addr,
  input  logic            reg_we,
  input  logic [CW-1:0]   reg_wdata,
  output logic [CW-1:0]   reg_rdata,
  input  logic [NSRC-1:0] tick_src,
  output logic            irq
);
  import tmr_pkg::*;

  localparam int SLW = AW - 4;

  logic [SLW-1:0]         slot;
  logic [3:0]             off;
  logic                   glob_hit;
  logic [NCH-1:0]         ch_hit;
  logic [NCH-1:0]         ien_q;
  logic [NCH-1:0]         sts_q;
  logic [NCH-1:0]         ch_expire;
  logic [NCH-1:0]         ch_active;
  logic [NCH-1:0]         ch_oneshot;
  logic [NCH-1:0][CW-1:0] ch_count;
  logic [NCH-1:0][CW-1:0] ch_ival;
  ctrl_t                  ch_ctrl [NCH];
  logic [NCH-1:0]         sts_clr;

  assign slot     = reg_addr[AW-1:4];
  assign off      = reg_addr[3:0];
  assign glob_hit = (slot == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [SLW-1:0] MY_SLOT = SLW'(i + 1);
    assign ch_hit[i] = (slot == MY_SLOT);

    tmr_channel #(.CW(CW), .NSRC(NSRC), .STOP_TICKS(STOP_TICKS)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctrl_we  (reg_we && ch_hit[i] && off == 4'h0),
      .ival_we  (reg_we && ch_hit[i] && off == 4'h4),
      .wdata    (reg_wdata),
      .tick_src (tick_src),
      .ctrl_rd  (ch_ctrl[i]),
      .ival     (ch_ival[i]),
      .count    (ch_count[i]),
      .expire   (ch_expire[i]),
      .active   (ch_active[i]),
      .oneshot  (ch_oneshot[i])
    );
  end

  assign sts_clr = (reg_we && glob_hit && off == 4'h4) ? reg_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien_q <= '0;
      sts_q <= '0;
    end else begin
      if (reg_we && glob_hit && off == 4'h0) ien_q <= reg_wdata[NCH-1:0];
      sts_q <= (sts_q & ~sts_clr) | ch_expire;
    end
  end

  assign irq = |(sts_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    if (glob_hit) begin
      if (off == 4'h0) reg_rdata = CW'(ien_q);
      if (off == 4'h4) reg_rdata = CW'(sts_q);
    end
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        if (off == 4'h0) reg_rdata = CW'(ch_ctrl[i]);
        if (off == 4'h4) reg_rdata = ch_ival[i];
        if (off == 4'h8) reg_rdata = ch_count[i];
      end
    end
  end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int NCH = 2,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [AW-1:0]          reg_addr,
  input logic                   reg_we,
  input logic [CW-1:0]          reg_wdata,
  input logic [CW-1:0]          reg_rdata,
  input logic                   irq,
  input logic [NCH-1:0]         ien_q,
  input logic [NCH-1:0]         sts_q,
  input logic [NCH-1:0]         ch_expire,
  input logic [NCH-1:0]         ch_active,
  input logic [NCH-1:0]         ch_oneshot,
  input logic [NCH-1:0][CW-1:0] ch_count,
  input logic [NCH-1:0][CW-1:0] ch_ival
);
  logic sts_wr;
  assign sts_wr = reg_we && (reg_addr == AW'(4));

  AST_IRQ_OFF_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq); // R9
  AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (sts_q != '0)); // R9
  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[1:0] != 2'b00) |-> (reg_rdata == '0)); // R1

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    localparam logic [AW-1:0] CTRL_A = AW'(16 * i + 16);
    logic ctrl_wr;
    assign ctrl_wr = reg_we && (reg_addr == CTRL_A);

    AST_RELOAD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == CTRL_A) |-> !reg_rdata[1]); // R2
    AST_EXPIRY_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      ch_expire[i] |-> ch_active[i]); // R3
    AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_expire[i] && !ch_oneshot[i]) |=> (ch_count[i] == $past(ch_ival[i]))); // R3
    AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_expire[i] && ch_oneshot[i] && !ctrl_wr) |=> (!ch_active[i] && ch_count[i] == '0)); // R4
    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_active[i] |=> $stable(ch_count[i])); // R7
    AST_PENDING_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      ch_expire[i] |=> sts_q[i]); // R8
    AST_PENDING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && reg_wdata[i] && !ch_expire[i]) |=> !sts_q[i]); // R8
    AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !(sts_wr && reg_wdata[i])) |=> sts_q[i]); // R8
  end

endmodule

bind countdown_timer_bank tmr_checker #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_addr   (reg_addr),
  .reg_we     (reg_we),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .irq        (irq),
  .ien_q      (ien_q),
  .sts_q      (sts_q),
  .ch_expire  (ch_expire),
  .ch_active  (ch_active),
  .ch_oneshot (ch_oneshot),
  .ch_count   (ch_count),
  .ch_ival    (ch_ival)
);

// File: tb/countdown_timer_bank_test.sv
module countdown_timer_bank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  tick_src = '0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  localparam logic [7:0] A_IEN = 8'h00, A_STS = 8'h04;
  localparam logic [7:0] A_C0 = 8'h10, A_I0 = 8'h14, A_N0 = 8'h18;
  localparam logic [7:0] A_C1 = 8'h20, A_I1 = 8'h24, A_N1 = 8'h28;

  always #10 clk = ~clk;

  countdown_timer_bank uut (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_we (reg_we),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .tick_src (tick_src), .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input int src, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_src[src] = 1'b1;
      @(negedge clk); tick_src[src] = 1'b0;
    end
  endtask

  task automatic t_reset;
    rd_chk("R11 ien", A_IEN, 0);
    rd_chk("R11 sts", A_STS, 0);
    rd_chk("R11 ctrl0", A_C0, 0);
    rd_chk("R11 count1", A_N1, 0);
    chk("R11 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_map;
    wr(A_C0, 32'h7C);
    rd_chk("R2 fields readback", A_C0, 32'h7C);
    wr(A_C0, 32'h7E);
    rd_chk("R2 reload reads zero", A_C0, 32'h7C);
    wr(A_C0, 32'h0);
    rd_chk("R1 unmapped 0x0C", 8'h0C, 0);
    rd_chk("R1 unmapped 0x1C", 8'h1C, 0);
    rd_chk("R1 missing channel", 8'h30, 0);
    rd_chk("R1 misaligned", 8'h11, 0);
    wr(A_N0, 32'h1234);
    rd_chk("R10 count write ignored", A_N0, 0);
  endtask

  task automatic t_periodic;
    wr(A_I0, 3);
    wr(A_C0, 32'h07);
    pulse(1, 1);
    rd_chk("R2 reload loads interval", A_N0, 3);
    rd_chk("R2 reload bit self-clears", A_C0, 32'h05);
    pulse(1, 2);
    rd_chk("R3 decrement", A_N0, 1);
    rd_chk("R3 no early expiry", A_STS, 0);
    pulse(1, 1);
    rd_chk("R3 periodic reload", A_N0, 3);
    rd_chk("R8 pending set while disabled", A_STS, 1);
    chk("R9 irq gated off", {31'b0, irq}, 0);
    wr(A_STS, 0);
    rd_chk("R8 write zero keeps", A_STS, 1);
    wr(A_IEN, 1);
    #1 chk("R9 irq raised", {31'b0, irq}, 1);
    wr(A_STS, 1);
    rd_chk("R8 write one clears", A_STS, 0);
    chk("R9 irq dropped", {31'b0, irq}, 0);
    wr(A_C0, 32'h04);
    pulse(1, 3);
    rd_chk("R7 two ticks after stop", A_N0, 1);
    pulse(1, 2);
    rd_chk("R7 stays stopped", A_N0, 1);
    rd_chk("R7 no expiry when stopped", A_STS, 0);
  endtask

  task automatic t_source;
    wr(A_I0, 10);
    wr(A_C0, 32'h07);
    pulse(0, 3);
    pulse(2, 2);
    rd_chk("R6 other inputs ignored before load", A_N0, 1);
    pulse(1, 1);
    rd_chk("R6 selected input loads", A_N0, 10);
    pulse(3, 5);
    rd_chk("R6 other inputs ignored", A_N0, 10);
    wr(A_C0, 32'h04);
    pulse(1, 2);
    rd_chk("R7 stop window counts", A_N0, 8);
  endtask

  task automatic t_prescale;
    wr(A_I1, 5);
    wr(A_C1, 32'h27);
    pulse(1, 3);
    rd_chk("R5 no count before 4th tick", A_N1, 0);
    pulse(1, 1);
    rd_chk("R5 4th tick counts", A_N1, 5);
    pulse(1, 3);
    rd_chk("R5 divided hold", A_N1, 5);
    pulse(1, 1);
    rd_chk("R5 next divided tick", A_N1, 4);
    wr(A_C1, 32'h24);
    pulse(1, 2);
    pulse(1, 8);
    rd_chk("R7 prescaled channel stopped", A_N1, 4);
  endtask

  task automatic t_oneshot;
    wr(A_I0, 2);
    wr(A_C0, 32'h87);
    pulse(1, 2);
    rd_chk("R4 counting", A_N0, 1);
    pulse(1, 1);
    rd_chk("R4 count zero at expiry", A_N0, 0);
    rd_chk("R4 run bit cleared", A_C0, 32'h84);
    rd_chk("R8 pending on one-shot", A_STS, 1);
    chk("R9 irq on one-shot", {31'b0, irq}, 1);
    wr(A_IEN, 2);
    #1 chk("R9 other channel enable only", {31'b0, irq}, 0);
    pulse(1, 3);
    rd_chk("R4 halted", A_N0, 0);
    wr(A_STS, 1);
    rd_chk("R8 cleared", A_STS, 0);
  endtask

  task automatic t_freerun;
    wr(A_I1, 32'hFFFF_FFFF);
    wr(A_C1, 32'h07);
    pulse(1, 1);
    rd_chk("R10 full range load", A_N1, 32'hFFFF_FFFF);
    pulse(1, 2);
    rd_chk("R10 down count", A_N1, 32'hFFFF_FFFD);
    @(negedge clk); reg_addr = A_N1; #1;
    chk("R10 inverse increments", ~reg_rdata, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_periodic();
    t_source();
    t_prescale();
    t_oneshot();
    t_freerun();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule